// File: doc/BRIEF.md
# Horizontal Polyphase Pixel Scaler

This block resamples one line of 32-bit pixels horizontally. The pixels have three colour components and an alpha byte. It first stores a whole input line of programmable length. It then emits an output line of programmable length. Each output pixel is either filtered through four taps or taken from its nearest input pixel. A fixed-point accumulator, with 20 fractional bits, advances by a programmed step for each output pixel. The integer part of the accumulator selects the input window. The top six fractional bits form the coefficient phase, and the block sends that phase to an external coefficient bank. The bank returns four signed taps in the same cycle.

Startup padding repeats input pixel 0 a programmable number of times at the head of the virtual input sequence. When a window runs past the end of the line, the last input pixel is repeated. Alpha is adjusted once before filtering and once after it, under two mode bits. A programmable number of leading output positions carry a fixed filler word instead of scaled data. When the enable input is low, the block is a wire: input and output streams are joined and pass untouched.

Pixel layout, used by every port that carries a pixel:
- component0 is in bits 31:24.
- component1 is in bits 23:16.
- component2 is in bits 15:8.
- alpha is in bits 7:0.

Top module: `hscale_poly`

## Requirements
- R1: After reset, with `en` high, `out_valid` is 0 and `in_ready` is 1.
- R2: With `en` low, `out_valid`, `out_data` and `out_sol` equal `in_valid`, `in_data` and `in_sol`, and `in_ready` equals `out_ready`.
- R3: With `en` high, the block accepts exactly `in_wm1`+1 pixels. A pixel with `in_sol` set is stored at position 0. After the last pixel is accepted, `in_ready` stays 0 until the whole output line is sent, and inputs offered during that time have no effect on the output.
- R4: An output line has `out_end`+1 pixels. Only the first one carries `out_sol`. Positions below `out_start` carry `dummy` unchanged.
- R5: Output position j ≥ `out_start` uses accumulator A = (j − `out_start`) · `step`. The window base is A >> 20, and `coef_phase` is bits 19:14 of A.
- R6: Window tap k (k = 0..3) reads input index base+k−`rpt0`. The index is clamped to 0 below and to `in_wm1` above.
- R7: In filter mode, each byte of the output equals clamp_0..255((Σ t_k·p_k + 64) >>> 7). Tap t_k is the signed 9-bit field `coef_taps`[9k+8:9k].
- R8: In nearest mode (`nearest`=1), the output is window tap 1 when `coef_phase` < 32 and tap 2 otherwise. `coef_taps` is ignored.
- R9: On entry, alpha a is replaced by a−1 when a ≥ 128 (`alpha_in_mode`=0) or when a ≥ 1 (`alpha_in_mode`=1).
- R10: After filtering, alpha a becomes a+1 when a ≥ 128 (`alpha_out_mode`=0) or when a ≥ 1 (`alpha_out_mode`=1). The result saturates at 255.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `coef_phase` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Scaler enable; low gives pass-through |
| nearest | input | 1 | Nearest-neighbour selection instead of filtering |
| alpha_in_mode | input | 1 | Entry alpha decrement threshold select |
| alpha_out_mode | input | 1 | Exit alpha increment threshold select |
| rpt0 | input | 2 | Extra copies of pixel 0 ahead of the line |
| in_wm1 | input | 13 | Input width minus one |
| out_start | input | 12 | First scaled output position |
| out_end | input | 12 | Last output position |
| step | input | 28 | Phase step, (in_width << 20) / out_width |
| dummy | input | 32 | Filler pixel word |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_sol | input | 1 | Input start of line |
| in_data | input | 32 | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output consumer ready |
| out_sol | output | 1 | Output start of line |
| out_data | output | 32 | Output pixel |
| coef_phase | output | 6 | Phase sent to the coefficient bank |
| coef_taps | input | 36 | Four signed 9-bit taps for coef_phase |

## Verification
Each kind of wrong internal state shows at the ports on a different output pixel:
- A wrong accumulator shows on the first output pixel after the padded positions, as a wrong byte value.
- A wrong pixel-0 repeat or a wrong end clamp shows only on the first or last few pixels of a line. For this reason, every line is compared pixel by pixel, edges included.
- A wrong line-buffer address shows as a corrupted pixel once the window reaches that position.
- A stuck fill or drain state shows within one cycle, on `in_ready`, or as a short or long output line.

Garbage is offered on the input during every drain, so an accept that leaks through corrupts a later pixel.

// File: rtl/hscale_poly.sv
`timescale 1ns/1ps
module hscale_poly #(
  parameter int MAXW = 64,
  parameter int FRAC = 20,
  parameter int CPB  = 6,
  parameter int TAPB = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                nearest,
  input  logic                alpha_in_mode,
  input  logic                alpha_out_mode,
  input  logic [1:0]          rpt0,
  input  logic [12:0]         in_wm1,
  input  logic [11:0]         out_start,
  input  logic [11:0]         out_end,
  input  logic [27:0]         step,
  input  logic [31:0]         dummy,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sol,
  input  logic [31:0]         in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_sol,
  output logic [31:0]         out_data,
  output logic [CPB-1:0]      coef_phase,
  input  logic [4*TAPB-1:0]   coef_taps
);
  localparam int AW   = $clog2(MAXW);
  localparam int IW   = 14;
  localparam int ACCW = IW + FRAC;
  localparam int SW   = 2 * TAPB + 4;

  function automatic logic [7:0] a_pre(input logic [7:0] a, input logic m);
    return ((m ? (a != 8'd0) : a[7]) ? a - 8'd1 : a);
  endfunction

  function automatic logic [7:0] a_post(input logic [7:0] a, input logic m);
    return (((m ? (a != 8'd0) : a[7]) && a != 8'hFF) ? a + 8'd1 : a);
  endfunction

  logic              emit;
  logic [12:0]       wcnt;
  logic [11:0]       ocnt;
  logic [ACCW-1:0]   acc;
  logic [31:0]       mem [MAXW];
  logic [31:0]       win [4];
  logic [31:0]       filt;
  logic [31:0]       core;
  logic [12:0]       waddr;
  logic              take;

  assign waddr = in_sol ? 13'd0 : wcnt;
  assign take  = en && !emit && in_valid;

  always_ff @(posedge clk) begin
    if (take)
      mem[AW'(waddr)] <= {in_data[31:8], a_pre(in_data[7:0], alpha_in_mode)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit <= 1'b0;
      wcnt <= '0;
      ocnt <= '0;
      acc  <= '0;
    end else if (!en) begin
      emit <= 1'b0;
      wcnt <= '0;
    end else if (!emit) begin
      if (in_valid) begin
        if (waddr == in_wm1) begin
          emit <= 1'b1;
          wcnt <= '0;
          ocnt <= '0;
          acc  <= '0;
        end else begin
          wcnt <= waddr + 13'd1;
        end
      end
    end else if (out_ready) begin
      ocnt <= ocnt + 12'd1;
      if (ocnt >= out_start) acc <= acc + ACCW'(step);
      if (ocnt == out_end) emit <= 1'b0;
    end
  end

  assign coef_phase = acc[FRAC-1 -: CPB];

  for (genvar k = 0; k < 4; k++) begin : g_win
    logic [14:0] n;
    logic [14:0] lo;
    logic [14:0] ix;
    assign n  = {1'b0, acc[ACCW-1:FRAC]} + 15'(k);
    assign lo = (n < 15'(rpt0)) ? 15'd0 : n - 15'(rpt0);
    assign ix = (lo > 15'(in_wm1)) ? 15'(in_wm1) : lo;
    assign win[k] = mem[AW'(ix)];
  end

  always_comb begin
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] tx;
    logic signed [SW-1:0] px;
    logic signed [SW-1:0] r;
    filt = '0;
    for (int c = 0; c < 4; c++) begin
      sum = '0;
      for (int k = 0; k < 4; k++) begin
        tx  = SW'($signed(coef_taps[k*TAPB +: TAPB]));
        px  = SW'({1'b0, win[k][c*8 +: 8]});
        sum = sum + tx * px;
      end
      r = (sum + SW'(64)) >>> 7;
      if (r < 0)                 filt[c*8 +: 8] = 8'd0;
      else if (r > SW'(255))     filt[c*8 +: 8] = 8'hFF;
      else                       filt[c*8 +: 8] = r[7:0];
    end
  end

  assign core = nearest ? (coef_phase[CPB-1] ? win[2] : win[1]) : filt;

  assign out_valid = en ? emit : in_valid;
  assign in_ready  = en ? !emit : out_ready;
  assign out_sol   = en ? (emit && ocnt == 12'd0) : in_sol;
  assign out_data  = !en ? in_data :
                     (ocnt < out_start) ? dummy :
                     {core[31:8], a_post(core[7:0], alpha_out_mode)};
endmodule

module hscale_poly_chk #(parameter int CPB = 6) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_sol,
  input logic [31:0]    out_data,
  input logic [11:0]    out_start,
  input logic [31:0]    dummy,
  input logic [CPB-1:0] coef_phase
);
  p_no_fill_during_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !(in_ready && out_valid));
  p_valid_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && out_valid && !out_ready |=> out_valid);
  p_phase_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && out_valid && !out_ready |=> $stable(coef_phase));
  p_pad_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && out_valid && out_sol && out_start != 12'd0 |-> out_data == dummy);
  p_phase_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && out_valid && out_sol |-> coef_phase == '0);
endmodule

bind hscale_poly hscale_poly_chk #(.CPB(CPB)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sol(out_sol),
  .out_data(out_data), .out_start(out_start), .dummy(dummy),
  .coef_phase(coef_phase));

// File: tb/test_hscale_poly.sv
`timescale 1ns/1ps
module test_hscale_poly;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en = 1'b1, nearest = 1'b0, am_i = 1'b0, am_o = 1'b0;
  logic [1:0] rpt0 = 2'd1;
  logic [12:0] in_wm1 = '0;
  logic [11:0] out_start = '0, out_end = '0;
  logic [27:0] step = '0;
  logic [31:0] dummy = 32'h80808080;
  logic in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sol;
  logic [31:0] out_data;
  logic [5:0] coef_phase;
  logic [35:0] coef_taps;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] vin [64];
  int iw_c;

  function automatic logic [35:0] coef_of(int ph);
    logic [8:0] t0, t1, t2, t3;
    t0 = 9'(-8); t1 = 9'(136 - 2*ph); t2 = 9'(2*ph + 8); t3 = 9'(-8);
    return {t3, t2, t1, t0};
  endfunction
  always_comb coef_taps = coef_of(int'(coef_phase));

  hscale_poly i_hscale_poly (
    .clk(clk), .rst_n(rst_n), .en(en), .nearest(nearest),
    .alpha_in_mode(am_i), .alpha_out_mode(am_o), .rpt0(rpt0),
    .in_wm1(in_wm1), .out_start(out_start), .out_end(out_end),
    .step(step), .dummy(dummy), .in_valid(in_valid), .in_ready(in_ready),
    .in_sol(in_sol), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sol(out_sol), .out_data(out_data),
    .coef_phase(coef_phase), .coef_taps(coef_taps));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pre_a(int a, bit m);
    return ((m ? a >= 1 : a >= 128) ? a - 1 : a);
  endfunction
  function automatic int post_a(int a, bit m);
    return (((m ? a >= 1 : a >= 128) && a < 255) ? a + 1 : a);
  endfunction

  // R5 R6 R7 R8 R9 R10 R4 reference
  function automatic logic [31:0] model(int j);
    longint a;
    int p, ph, n, ix, s, r;
    int w [4][4];
    logic [31:0] res;
    if (j < int'(out_start)) return dummy;
    a  = longint'(j - int'(out_start)) * longint'(step);
    p  = int'(a >> 20);
    ph = int'((a >> 14) & 63);
    for (int k = 0; k < 4; k++) begin
      n  = p + k;
      ix = (n < int'(rpt0)) ? 0 : n - int'(rpt0);
      if (ix > iw_c - 1) ix = iw_c - 1;
      for (int c = 0; c < 4; c++) w[k][c] = int'(vin[ix][c*8 +: 8]);
      w[k][0] = pre_a(w[k][0], am_i);
    end
    for (int c = 0; c < 4; c++) begin
      if (nearest) r = (ph >= 32) ? w[2][c] : w[1][c];
      else begin
        s = -8*w[0][c] + (136 - 2*ph)*w[1][c] + (2*ph + 8)*w[2][c] - 8*w[3][c];
        r = (s + 64) >>> 7;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
      end
      res[c*8 +: 8] = 8'(r);
    end
    res[7:0] = 8'(post_a(int'(res[7:0]), am_o));
    return res;
  endfunction

  task automatic setup(int iw, int ow, int st, int rp, bit nr, bit mi, bit mo);
    iw_c = iw; in_wm1 = 13'(iw - 1); out_start = 12'(st);
    out_end = 12'(st + ow - 1); step = 28'((longint'(iw) << 20) / ow);
    rpt0 = 2'(rp); nearest = nr; am_i = mi; am_o = mo;
  endtask

  task automatic run_line(bit bp, string tag);
    int j = 0, cyc = 0;
    bit stalled = 0;
    logic [31:0] held = '0;
    for (int i = 0; i < iw_c; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = vin[i]; in_sol = (i == 0);
      #1 chk(in_ready == 1'b1, "R3 fill ready", 32'(in_ready), 32'd1);
    end
    while (j <= int'(out_end)) begin
      @(negedge clk);
      in_valid = 1'b1; in_sol = 1'b1; in_data = 32'hDEADBEEF;
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (stalled) chk(out_data == held && out_valid, "R11 hold", out_data, held);
      stalled = 1'b0;
      if (out_valid && out_ready) begin
        chk(out_data == model(j), tag, out_data, model(j));
        chk(out_sol == (j == 0), "R4 sol", 32'(out_sol), 32'(j == 0));
        if (j == 0) chk(in_ready == 1'b0, "R3 drain not ready", 32'(in_ready), 32'd0);
        j++;
      end else if (out_valid) begin
        stalled = 1'b1; held = out_data;
      end else begin
        chk(1'b0, "R4 line short", 32'(j), 32'(out_end) + 1);
        j = int'(out_end) + 1;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; out_ready = 1'b0;
    #1 chk(out_valid == 1'b0 && in_ready == 1'b1, "R4 line length", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int alist [8] = '{0, 1, 5, 127, 128, 129, 254, 255};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // R2 bypass
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = i[0]; in_sol = (i == 2); in_data = 32'h1234_5600 + 32'(i * 77);
      out_ready = (i < 3);
      #1;
      chk(out_valid == in_valid && out_sol == in_sol, "R2 valid/sol", 32'(out_valid), 32'(in_valid));
      chk(out_data == in_data, "R2 data", out_data, in_data);
      chk(in_ready == out_ready, "R2 ready", 32'(in_ready), 32'(out_ready));
    end
    @(negedge clk); in_valid = 0; in_sol = 0; out_ready = 0; en = 1'b1;

    // R8 R9 R10: unity nearest over alpha modes
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++)
        vin[i] = {8'(i*37+11), 8'(i*91+200), 8'(255-i*23), 8'(alist[i])};
      setup(8, 8, 0, 1, 1'b1, m[0], m[1]);
      run_line(1'b0, "R9 R10 alpha");
    end

    for (int i = 0; i < 64; i++)
      vin[i] = {8'(i*37+11), 8'(i*91+200), 8'(255-i*23), 8'(i*53+130)};
    setup(5, 12, 0, 1, 1'b0, 1'b0, 1'b0);   run_line(1'b0, "R5 R6 R7 upscale");
    setup(16, 7, 0, 0, 1'b0, 1'b1, 1'b0);   run_line(1'b1, "R5 R7 downscale");
    setup(6, 10, 3, 1, 1'b0, 1'b0, 1'b1);   run_line(1'b1, "R4 pad");
    setup(4, 11, 0, 2, 1'b1, 1'b0, 1'b0);   run_line(1'b0, "R6 R8 nearest rpt2");
    setup(9, 9, 0, 3, 1'b0, 1'b1, 1'b1);    run_line(1'b0, "R6 edge rpt3");
    for (int i = 0; i < 8; i++) vin[i] = i[0] ? 32'hFFFFFFFF : 32'h0;
    setup(8, 13, 0, 1, 1'b0, 1'b0, 1'b0);   run_line(1'b1, "R7 clamp");
    dummy = 32'h11223344;
    setup(3, 5, 2, 1, 1'b0, 1'b1, 1'b1);    run_line(1'b0, "R4 dummy word");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule